// File: doc/BRIEF.md
# Low-Power Hold Sequencer

This block walks a chip into and out of a low-power hold state without losing any register or memory contents. An external active-low request pin is brought into the clock domain through a flop synchroniser. While the chip is running, a pending request is shown to user core logic. The user logic decides when the core is quiet enough and answers with a grant. Until that grant arrives, nothing changes.

On a grant, the block first takes over every user output pad. Each pad is set to a behaviour chosen for that pad alone: keep its last driven value and enable, float, drive low, or drive high. After a fixed settle window, the core clock is stopped through a latch-based gate that cannot produce a shortened pulse. While the block is held, the core receives no clock edges, and changes on the core's pad outputs do not reach the pins.

When the pin is released, the block reverses the order. The clock restarts first. After the settle window the pads return to the core. A static strap input turns the feature off. The pin is then only a synchronised general-purpose input. Control and status are plain level signals. There is no data stream, so there is no valid/ready handshake and no back-pressure to follow.

Top module: `lp_hold_ctrl`

## Requirements
- R1: After reset the state output is 00 (running), the user request is 0, the clock enable is 1, and every pad output and pad enable equals the core's value for it.
- R2: The request pin is active low and passes through SYNC_STAGES flops. With the default of 2, the user request goes to 1 in the second clock after the pin is sampled low. It is asserted only in state 00, and only while the strap enable is 1.
- R3: The state stays 00 for as long as the grant input is 0, whether or not a request is pending. A grant with no pending request has no effect.
- R4: A grant while the request is shown moves the state to 01 (entering) on the next edge. The state stays 01 for SETTLE_CYCLES cycles with the clock still enabled. It then becomes 10 (frozen), where the clock enable is 0.
- R5: From state 01 until the return to 00, each pad follows its 2-bit field io_cfg[2i+1:2i]. The codes are: 00 keeps the data and enable captured at the grant edge; 01 gives enable 0 with data 0; 10 gives enable 1 with data 0; 11 gives enable 1 with data 1.
- R6: In state 10, the gated core clock shows no rising edge, and changes on the core's pad data or enable do not change the pads.
- R7: Once the synchronised pin reads high in state 10, the state moves to 11 (exiting) on the next edge and the clock enable returns to 1. The pads stay overridden for SETTLE_CYCLES cycles. The state then returns to 00, and the pads follow the core again.
- R8: With the strap enable at 0, a low pin never raises the user request or leaves state 00. The synchronised pin level is always available on pin_io_in.
- R9: If the pin is released before the grant, the user request drops and a later grant is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_enable | input | 1 | Static strap: 1 uses the pin as the hold request |
| frz_req_n | input | 1 | Active-low hold request pin |
| pin_io_in | output | 1 | Synchronised pin level, for use as an ordinary input |
| usr_req | output | 1 | Hold request shown to user logic |
| usr_grant | input | 1 | User logic consent to enter the hold |
| core_clk_en | output | 1 | Core clock enable, 0 while frozen |
| core_gclk | output | 1 | Glitch-free gated core clock |
| io_cfg | input | 2*NUM_IO | Per-pad hold behaviour, 2 bits each |
| core_do | input | NUM_IO | Pad data from the core |
| core_oe | input | NUM_IO | Pad output enable from the core |
| pad_do | output | NUM_IO | Data to the pads |
| pad_oe | output | NUM_IO | Output enable to the pads |
| state | output | 2 | 00 running, 01 entering, 10 frozen, 11 exiting |

## Verification
The bench builds the block with NUM_IO=4, SYNC_STAGES=2 and SETTLE_CYCLES=3. Four pads are enough for a single configuration word to mix all four pad codes. They also let the pad vectors be written out as short literals. A settle window of three cycles puts the edges between the entering, frozen and exiting states a few cycles apart. This lets the bench sample the last cycle before each transition and the first cycle after it.

// File: rtl/lp_hold_pkg.sv
package lp_hold_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_ENTER  = 2'b01,
    ST_FROZEN = 2'b10,
    ST_EXIT   = 2'b11
  } lp_state_e;

  typedef enum logic [1:0] {
    IO_HOLD = 2'b00,
    IO_TRI  = 2'b01,
    IO_LOW  = 2'b10,
    IO_HIGH = 2'b11
  } io_mode_e;
endpackage

// File: rtl/lp_req_sync.sv
module lp_req_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/lp_hold_fsm.sv
module lp_hold_fsm
  import lp_hold_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       enable,
  input  logic       grant,
  output logic [1:0] state_o,
  output logic       usr_req,
  output logic       clk_en,
  output logic       ovr
);
  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  lp_state_e        st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      ST_ACTIVE: begin
        cnt_nx = '0;
        if (usr_req && grant) st_nx = ST_ENTER;
      end
      ST_ENTER: begin
        if (cnt == CNT_LAST) begin
          st_nx  = ST_FROZEN;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      ST_FROZEN: begin
        cnt_nx = '0;
        if (!req) st_nx = ST_EXIT;
      end
      ST_EXIT: begin
        if (cnt == CNT_LAST) begin
          st_nx  = ST_ACTIVE;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      default: st_nx = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_ACTIVE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign usr_req = (st == ST_ACTIVE) && req && enable;
  assign clk_en  = (st != ST_FROZEN);
  assign ovr     = (st != ST_ACTIVE);
  assign state_o = st;
endmodule

// File: rtl/lp_clk_gate.sv
module lp_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_l;

  always_latch
    if (!clk) en_l = en;

  assign gclk = clk & en_l;
endmodule

// File: rtl/lp_io_override.sv
module lp_io_override
  import lp_hold_pkg::*;
#(
  parameter int NUM_IO = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ovr,
  input  logic [2*NUM_IO-1:0] cfg,
  input  logic [NUM_IO-1:0]   core_do,
  input  logic [NUM_IO-1:0]   core_oe,
  output logic [NUM_IO-1:0]   pad_do,
  output logic [NUM_IO-1:0]   pad_oe
);
  generate
    for (genvar i = 0; i < NUM_IO; i++) begin : g_pad
      logic     hold_do, hold_oe;
      io_mode_e mode;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          hold_do <= 1'b0;
          hold_oe <= 1'b0;
        end else if (!ovr) begin
          hold_do <= core_do[i];
          hold_oe <= core_oe[i];
        end

      assign mode = io_mode_e'(cfg[2*i +: 2]);

      always_comb begin
        if (!ovr) begin
          pad_do[i] = core_do[i];
          pad_oe[i] = core_oe[i];
        end else begin
          unique case (mode)
            IO_HOLD: begin pad_do[i] = hold_do; pad_oe[i] = hold_oe; end
            IO_TRI:  begin pad_do[i] = 1'b0;    pad_oe[i] = 1'b0;    end
            IO_LOW:  begin pad_do[i] = 1'b0;    pad_oe[i] = 1'b1;    end
            IO_HIGH: begin pad_do[i] = 1'b1;    pad_oe[i] = 1'b1;    end
            default: begin pad_do[i] = 1'b0;    pad_oe[i] = 1'b0;    end
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lp_hold_ctrl.sv
module lp_hold_ctrl #(
  parameter int NUM_IO        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frz_enable,
  input  logic                frz_req_n,
  output logic                pin_io_in,
  output logic                usr_req,
  input  logic                usr_grant,
  output logic                core_clk_en,
  output logic                core_gclk,
  input  logic [2*NUM_IO-1:0] io_cfg,
  input  logic [NUM_IO-1:0]   core_do,
  input  logic [NUM_IO-1:0]   core_oe,
  output logic [NUM_IO-1:0]   pad_do,
  output logic [NUM_IO-1:0]   pad_oe,
  output logic [1:0]          state
);
  logic pin_s;
  logic ovr;

  lp_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(frz_req_n), .q(pin_s)
  );

  assign pin_io_in = pin_s;

  lp_hold_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(!pin_s), .enable(frz_enable),
    .grant(usr_grant), .state_o(state), .usr_req(usr_req),
    .clk_en(core_clk_en), .ovr(ovr)
  );

  lp_clk_gate u_cg (.clk(clk), .en(core_clk_en), .gclk(core_gclk));

  lp_io_override #(.NUM_IO(NUM_IO)) u_io (
    .clk(clk), .rst_n(rst_n), .ovr(ovr), .cfg(io_cfg),
    .core_do(core_do), .core_oe(core_oe), .pad_do(pad_do), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/lp_hold_ctrl_chk.sv
module lp_hold_ctrl_chk #(
  parameter int NUM_IO = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        state,
  input logic              core_clk_en,
  input logic              usr_req,
  input logic              usr_grant,
  input logic              frz_enable,
  input logic [NUM_IO-1:0] pad_do,
  input logic [NUM_IO-1:0] pad_oe
);
  p_run_clock_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00) |-> core_clk_en);

  p_req_only_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    usr_req |-> (state == 2'b00 && frz_enable));

  p_no_entry_wo_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b00 && !usr_grant) |=> (state == 2'b00));

  p_enter_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b01) |=> (state == 2'b01 || state == 2'b10));

  p_frozen_clock_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b10) |-> !core_clk_en);

  p_pads_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b10) |=> (state != 2'b10 || ($stable(pad_do) && $stable(pad_oe))));

  p_exit_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b11) |=> (state == 2'b11 || state == 2'b00));

  p_frozen_leaves_to_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'b10) |=> (state == 2'b10 || state == 2'b11));
endmodule

bind lp_hold_ctrl lp_hold_ctrl_chk #(.NUM_IO(NUM_IO)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .core_clk_en(core_clk_en),
  .usr_req(usr_req), .usr_grant(usr_grant), .frz_enable(frz_enable),
  .pad_do(pad_do), .pad_oe(pad_oe)
);

// File: tb/tb_lp_hold_ctrl.sv
module tb_lp_hold_ctrl;
  localparam int N  = 4;
  localparam int SS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frz_enable = 1'b1;
  logic frz_req_n = 1'b1;
  logic usr_grant = 1'b0;
  logic [2*N-1:0] io_cfg = '0;
  logic [N-1:0] core_do = '0, core_oe = '0;
  logic pin_io_in, usr_req, core_clk_en, core_gclk;
  logic [N-1:0] pad_do, pad_oe;
  logic [1:0] state;

  int n_chk = 0, n_err = 0, gcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge core_gclk) gcnt++;

  lp_hold_ctrl #(.NUM_IO(N), .SYNC_STAGES(2), .SETTLE_CYCLES(SS)) dut (
    .clk(clk), .rst_n(rst_n), .frz_enable(frz_enable), .frz_req_n(frz_req_n),
    .pin_io_in(pin_io_in), .usr_req(usr_req), .usr_grant(usr_grant),
    .core_clk_en(core_clk_en), .core_gclk(core_gclk), .io_cfg(io_cfg),
    .core_do(core_do), .core_oe(core_oe), .pad_do(pad_do), .pad_oe(pad_oe),
    .state(state)
  );

  // {cfg, core_do, core_oe, exp_do, exp_oe}
  localparam logic [23:0] VEC [4] = '{
    {8'b00_00_00_00, 4'b1010, 4'b1100, 4'b1010, 4'b1100},
    {8'b01_01_01_01, 4'b1111, 4'b1111, 4'b0000, 4'b0000},
    {8'b11_10_01_00, 4'b0111, 4'b0101, 4'b1001, 4'b1101},
    {8'b00_11_10_00, 4'b0100, 4'b0011, 4'b0100, 4'b0111}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    core_do = 4'b0110; core_oe = 4'b1011;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 state", state, 2'b00);
    chk("R1 usr_req", usr_req, 0);
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 pad_do", pad_do, core_do);
    chk("R1 pad_oe", pad_oe, core_oe);

    // R3 grant without request
    usr_grant = 1; step(2);
    chk("R3 grant alone", state, 2'b00);
    usr_grant = 0;

    // vector loop: R2 R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      int g0;
      io_cfg = VEC[v][23:16]; core_do = VEC[v][15:12]; core_oe = VEC[v][11:8];
      frz_req_n = 0;
      step(1);
      chk("R2 sync delay", usr_req, 0);
      step(1);
      chk("R2 usr_req", usr_req, 1);
      step(2);
      chk("R3 waits for grant", state, 2'b00);
      usr_grant = 1; step(1); usr_grant = 0;
      chk("R4 entering", state, 2'b01);
      chk("R4 clk on", core_clk_en, 1);
      chk("R5 pad_do", pad_do, VEC[v][7:4]);
      chk("R5 pad_oe", pad_oe, VEC[v][3:0]);
      step(SS-1);
      chk("R4 still entering", state, 2'b01);
      step(1);
      chk("R4 frozen", state, 2'b10);
      chk("R4 clk off", core_clk_en, 0);
      g0 = gcnt;
      core_do = ~core_do; core_oe = ~core_oe;
      step(4);
      chk("R6 pad_do", pad_do, VEC[v][7:4]);
      chk("R6 pad_oe", pad_oe, VEC[v][3:0]);
      chk("R6 no gclk", gcnt, g0);
      frz_req_n = 1;
      step(2);
      chk("R7 still frozen", state, 2'b10);
      step(1);
      chk("R7 exiting", state, 2'b11);
      chk("R7 clk on", core_clk_en, 1);
      chk("R7 pads held", pad_do, VEC[v][7:4]);
      step(SS-1);
      chk("R7 still exiting", state, 2'b11);
      step(1);
      chk("R7 running", state, 2'b00);
      chk("R7 pad_do back", pad_do, core_do);
      chk("R7 pad_oe back", pad_oe, core_oe);
    end

    // R9 release before grant
    frz_req_n = 0; step(2);
    chk("R9 req up", usr_req, 1);
    frz_req_n = 1; step(2);
    chk("R9 req dropped", usr_req, 0);
    usr_grant = 1; step(2); usr_grant = 0;
    chk("R9 no entry", state, 2'b00);

    // R8 feature off
    frz_enable = 0; frz_req_n = 0; usr_grant = 1;
    step(3);
    chk("R8 pin_io_in low", pin_io_in, 0);
    chk("R8 no req", usr_req, 0);
    chk("R8 state", state, 2'b00);
    frz_req_n = 1; usr_grant = 0; step(2);
    chk("R8 pin_io_in high", pin_io_in, 1);

    done = 1;
    finish_run();
  end
endmodule